// File: doc/BRIEF.md
# Input-Capture Channel with Two-Entry Holding Queue

This block is one input-capture channel. When the edge strobe arrives, the channel stores the value of a free-running timer in its capture register. The capture register and a holding register behind it form a queue with two entries. Each entry has a full bit. The full bit is set when the entry is loaded and cleared when software reads the entry. Software reads are signalled by two strobes, one for each register.

A no-overwrite control decides what a new capture does to stored data:
- With the control cleared, every capture moves the old capture value into the holding register.
- With the control set, a stored value is kept until it has been read or moved along.

A flag-mode control chooses when the channel flag is raised:
- With the control cleared, the flag is raised on every accepted capture.
- With the control set, the flag is raised only when a valid entry moves into the holding register.

Reading the holding register also takes a snapshot of an external pulse-accumulator count. The bus decoder and the timer counter sit outside this block.

Top module: `cap_queue`

## Requirements
- R1: After reset, capture and holding registers read zero, both full bits are 0, the flag is 0 and the accumulator snapshot is zero.
- R2: A capture into an empty capture register stores `timer_i` of that cycle in `cap_o` and sets `cap_full_o` on the next clock edge.
- R3: With `no_ovw_i`=0, a capture copies `cap_o` into `hold_o`, gives `hold_full_o` the capture register's full state, and loads `timer_i` into `cap_o` with `cap_full_o`=1.
- R4: With `no_ovw_i`=1, a capture loads only the capture register if that register is empty. If it is full and the holding register is empty, the capture moves the capture value to the holding register and then loads the capture register; both become full.
- R5: With `no_ovw_i`=1 and both registers full, a capture changes no register, no full bit and no flag.
- R6: `rd_cap_i` clears `cap_full_o` and `rd_hold_i` clears `hold_full_o`, and the stored values stay unchanged. A read in the same cycle as a capture counts first, so the capture sees that register as empty.
- R7: With `flag_mode_i`=0, the flag is set on every capture that loads the capture register.
- R8: With `flag_mode_i`=1, the flag is set only when a full capture entry moves into the holding register. A load into an empty capture register leaves the flag clear.
- R9: `flag_clr_i`=1 clears the flag. A flag-set event in the same cycle wins over the clear.
- R10: `rd_hold_i` stores `pacc_i` of that cycle in `pacc_hold_o`. Without `rd_hold_i`, `pacc_hold_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_evt_i | input | 1 | One-cycle strobe: valid edge seen |
| timer_i | input | TMR_W | Free-running timer value |
| rd_cap_i | input | 1 | Read strobe for the capture register |
| rd_hold_i | input | 1 | Read strobe for the holding register |
| no_ovw_i | input | 1 | 1 = do not overwrite full entries |
| flag_mode_i | input | 1 | 1 = flag only on transfer to holding register |
| flag_clr_i | input | 1 | Write-one-to-clear for the flag |
| pacc_i | input | PACC_W | Pulse-accumulator count |
| cap_o | output | TMR_W | Capture register |
| hold_o | output | TMR_W | Holding register |
| cap_full_o | output | 1 | Capture register holds unread data |
| hold_full_o | output | 1 | Holding register holds unread data |
| flag_o | output | 1 | Channel flag |
| pacc_hold_o | output | PACC_W | Accumulator snapshot |

## Verification
The assertions assume that every strobe input is a clean synchronous level that is known whenever reset is released. They also assume that the controls `no_ovw_i` and `flag_mode_i` are sampled in the same cycle as the strobes they qualify. The bench drives all inputs at the falling edge and holds each strobe for exactly one cycle. It changes mode controls only between scenarios, so each assertion's antecedent sees a steady mode. The drop check in R5 only fires when no read is present in that cycle, and the stimulus separates drop cases from read cases to match.

// File: rtl/cap_queue_pkg.sv
package cap_queue_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2,
    ACT_DROP  = 2'd3
  } cap_act_e;
endpackage

// File: rtl/cq_accept.sv
module cq_accept
  import cap_queue_pkg::*;
(
  input  logic     evt_i,
  input  logic     no_ovw_i,
  input  logic     cap_full_eff_i,
  input  logic     hold_full_eff_i,
  output cap_act_e act_o,
  output logic     xfer_o
);
  always_comb begin
    act_o = ACT_IDLE;
    if (evt_i) begin
      if (!no_ovw_i)            act_o = ACT_SHIFT;
      else if (!cap_full_eff_i) act_o = ACT_LOAD;
      else if (!hold_full_eff_i) act_o = ACT_SHIFT;
      else                      act_o = ACT_DROP;
    end
  end

  // a transfer only counts when a valid entry moves
  assign xfer_o = (act_o == ACT_SHIFT) && cap_full_eff_i;
endmodule

// File: rtl/cq_store.sv
module cq_store
  import cap_queue_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cap_act_e         act_i,
  input  logic [TMR_W-1:0] timer_i,
  input  logic             rd_cap_i,
  input  logic             rd_hold_i,
  output logic             cap_full_eff_o,
  output logic             hold_full_eff_o,
  output logic [TMR_W-1:0] cap_o,
  output logic [TMR_W-1:0] hold_o,
  output logic             cap_full_o,
  output logic             hold_full_o
);
  // reads of this cycle count before the capture decision
  assign cap_full_eff_o  = cap_full_o  & ~rd_cap_i;
  assign hold_full_eff_o = hold_full_o & ~rd_hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o       <= '0;
      hold_o      <= '0;
      cap_full_o  <= 1'b0;
      hold_full_o <= 1'b0;
    end else begin
      unique case (act_i)
        ACT_LOAD: begin
          cap_o       <= timer_i;
          cap_full_o  <= 1'b1;
          hold_full_o <= hold_full_eff_o;
        end
        ACT_SHIFT: begin
          hold_o      <= cap_o;
          hold_full_o <= cap_full_eff_o;
          cap_o       <= timer_i;
          cap_full_o  <= 1'b1;
        end
        default: begin
          cap_full_o  <= cap_full_eff_o;
          hold_full_o <= hold_full_eff_o;
        end
      endcase
    end
  end
endmodule

// File: rtl/cq_flag.sv
module cq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic xfer_i,
  input  logic flag_mode_i,
  input  logic flag_clr_i,
  output logic flag_o
);
  logic set_w;

  assign set_w = flag_mode_i ? xfer_i : accept_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (set_w)      flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/cap_queue.sv
module cap_queue
  import cap_queue_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int PACC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_evt_i,
  input  logic [TMR_W-1:0]  timer_i,
  input  logic              rd_cap_i,
  input  logic              rd_hold_i,
  input  logic              no_ovw_i,
  input  logic              flag_mode_i,
  input  logic              flag_clr_i,
  input  logic [PACC_W-1:0] pacc_i,
  output logic [TMR_W-1:0]  cap_o,
  output logic [TMR_W-1:0]  hold_o,
  output logic              cap_full_o,
  output logic              hold_full_o,
  output logic              flag_o,
  output logic [PACC_W-1:0] pacc_hold_o
);
  cap_act_e act_w;
  logic     xfer_w;
  logic     cap_full_eff_w;
  logic     hold_full_eff_w;
  logic     accept_w;

  cq_accept u_accept (
    .evt_i           (cap_evt_i),
    .no_ovw_i        (no_ovw_i),
    .cap_full_eff_i  (cap_full_eff_w),
    .hold_full_eff_i (hold_full_eff_w),
    .act_o           (act_w),
    .xfer_o          (xfer_w)
  );

  cq_store #(.TMR_W(TMR_W)) u_store (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .act_i           (act_w),
    .timer_i         (timer_i),
    .rd_cap_i        (rd_cap_i),
    .rd_hold_i       (rd_hold_i),
    .cap_full_eff_o  (cap_full_eff_w),
    .hold_full_eff_o (hold_full_eff_w),
    .cap_o           (cap_o),
    .hold_o          (hold_o),
    .cap_full_o      (cap_full_o),
    .hold_full_o     (hold_full_o)
  );

  assign accept_w = (act_w == ACT_LOAD) || (act_w == ACT_SHIFT);

  cq_flag u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept_w),
    .xfer_i      (xfer_w),
    .flag_mode_i (flag_mode_i),
    .flag_clr_i  (flag_clr_i),
    .flag_o      (flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pacc_hold_o <= '0;
    else if (rd_hold_i) pacc_hold_o <= pacc_i;
  end
endmodule

// File: rtl/cap_queue_chk.sv
module cap_queue_chk #(
  parameter int TMR_W  = 16,
  parameter int PACC_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cap_evt_i,
  input logic [TMR_W-1:0]  timer_i,
  input logic              rd_cap_i,
  input logic              rd_hold_i,
  input logic              no_ovw_i,
  input logic              flag_mode_i,
  input logic              flag_clr_i,
  input logic [PACC_W-1:0] pacc_i,
  input logic [TMR_W-1:0]  cap_o,
  input logic [TMR_W-1:0]  hold_o,
  input logic              cap_full_o,
  input logic              hold_full_o,
  input logic              flag_o,
  input logic [PACC_W-1:0] pacc_hold_o
);
  a_r3_shift_on_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i && !no_ovw_i) |=>
      (cap_o == $past(timer_i) && hold_o == $past(cap_o) && cap_full_o));

  a_r5_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i && no_ovw_i && cap_full_o && hold_full_o && !rd_cap_i && !rd_hold_i) |=>
      ($stable(cap_o) && $stable(hold_o) && cap_full_o && hold_full_o));

  a_r6_read_clears_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cap_i && !cap_evt_i) |=> (!cap_full_o && $stable(cap_o)));

  a_r7_flag_on_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i && !no_ovw_i && !flag_mode_i) |=> flag_o);

  a_r8_no_flag_on_plain_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i && flag_mode_i && !cap_full_o && !flag_o) |=> !flag_o);

  a_r10_pacc_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hold_i |=> (pacc_hold_o == $past(pacc_i)));
endmodule

bind cap_queue cap_queue_chk #(.TMR_W(TMR_W), .PACC_W(PACC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cap_evt_i   (cap_evt_i),
  .timer_i     (timer_i),
  .rd_cap_i    (rd_cap_i),
  .rd_hold_i   (rd_hold_i),
  .no_ovw_i    (no_ovw_i),
  .flag_mode_i (flag_mode_i),
  .flag_clr_i  (flag_clr_i),
  .pacc_i      (pacc_i),
  .cap_o       (cap_o),
  .hold_o      (hold_o),
  .cap_full_o  (cap_full_o),
  .hold_full_o (hold_full_o),
  .flag_o      (flag_o),
  .pacc_hold_o (pacc_hold_o)
);

// File: tb/cap_queue_bench.sv
module cap_queue_bench;
  localparam int TMR_W  = 16;
  localparam int PACC_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cap_evt_i = 1'b0;
  logic [TMR_W-1:0]  timer_i = '0;
  logic              rd_cap_i = 1'b0;
  logic              rd_hold_i = 1'b0;
  logic              no_ovw_i = 1'b0;
  logic              flag_mode_i = 1'b0;
  logic              flag_clr_i = 1'b0;
  logic [PACC_W-1:0] pacc_i = '0;
  logic [TMR_W-1:0]  cap_o;
  logic [TMR_W-1:0]  hold_o;
  logic              cap_full_o;
  logic              hold_full_o;
  logic              flag_o;
  logic [PACC_W-1:0] pacc_hold_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  cap_queue #(.TMR_W(TMR_W), .PACC_W(PACC_W)) u_cap_queue (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes at negedge, sample at the next negedge
  task automatic step(logic evt, logic [TMR_W-1:0] t, logic rc, logic rh,
                      logic clr, logic [PACC_W-1:0] pa);
    cap_evt_i = evt; timer_i = t; rd_cap_i = rc; rd_hold_i = rh;
    flag_clr_i = clr; pacc_i = pa;
    @(negedge clk_i);
    cap_evt_i = 1'b0; rd_cap_i = 1'b0; rd_hold_i = 1'b0; flag_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cap", cap_o, 0);
    chk("R1 hold", hold_o, 0);
    chk("R1 full", {cap_full_o, hold_full_o}, 0);
    chk("R1 flag", flag_o, 0);
    chk("R1 pacc", pacc_hold_o, 0);
  endtask

  task automatic t_overwrite();
    no_ovw_i = 1'b0; flag_mode_i = 1'b0;
    step(1, 16'h0011, 0, 0, 0, 0);
    chk("R2 cap", cap_o, 16'h0011);
    chk("R2 full", {cap_full_o, hold_full_o}, 2'b10);
    chk("R7 flag", flag_o, 1);
    step(0, 0, 0, 0, 1, 0);
    chk("R9 clear", flag_o, 0);
    step(1, 16'h0022, 0, 0, 0, 0);
    chk("R3 cap", cap_o, 16'h0022);
    chk("R3 hold", hold_o, 16'h0011);
    chk("R3 full", {cap_full_o, hold_full_o}, 2'b11);
    chk("R7 flag again", flag_o, 1);
  endtask

  task automatic t_no_overwrite();
    step(0, 0, 1, 1, 1, 0);
    chk("R6 empty", {cap_full_o, hold_full_o}, 2'b00);
    chk("R6 values kept", {cap_o, hold_o}, {16'h0022, 16'h0011});
    no_ovw_i = 1'b1;
    step(1, 16'h0033, 0, 0, 0, 0);
    chk("R4 load cap", {cap_o, hold_o}, {16'h0033, 16'h0011});
    chk("R4 load full", {cap_full_o, hold_full_o}, 2'b10);
    step(1, 16'h0044, 0, 0, 0, 0);
    chk("R4 shift", {cap_o, hold_o}, {16'h0044, 16'h0033});
    chk("R4 shift full", {cap_full_o, hold_full_o}, 2'b11);
    step(0, 0, 0, 0, 1, 0);
    step(1, 16'h0055, 0, 0, 0, 0);
    chk("R5 drop values", {cap_o, hold_o}, {16'h0044, 16'h0033});
    chk("R5 drop full", {cap_full_o, hold_full_o}, 2'b11);
    chk("R5 drop flag", flag_o, 0);
    step(1, 16'h0066, 1, 0, 0, 0);
    chk("R6 read-first", {cap_o, hold_o}, {16'h0066, 16'h0033});
    chk("R6 read-first full", {cap_full_o, hold_full_o}, 2'b11);
  endtask

  task automatic t_flag_mode();
    flag_mode_i = 1'b1; no_ovw_i = 1'b1;
    step(0, 0, 1, 1, 1, 0);
    chk("R8 start", {flag_o, cap_full_o, hold_full_o}, 3'b000);
    step(1, 16'h0070, 0, 0, 0, 0);
    chk("R8 load no flag", flag_o, 0);
    chk("R8 cap", cap_o, 16'h0070);
    step(1, 16'h0071, 0, 0, 0, 0);
    chk("R8 flag on xfer", flag_o, 1);
    chk("R8 hold", hold_o, 16'h0070);
    // set wins over clear: normal mode, overwrite, capture + clear together
    flag_mode_i = 1'b0; no_ovw_i = 1'b0;
    step(1, 16'h0072, 0, 0, 1, 0);
    chk("R9 set wins", flag_o, 1);
    step(0, 0, 0, 0, 1, 0);
    chk("R9 cleared", flag_o, 0);
  endtask

  task automatic t_pacc();
    step(0, 0, 0, 1, 0, 16'hA5A5);
    chk("R10 latch", pacc_hold_o, 16'hA5A5);
    step(0, 0, 0, 0, 0, 16'h1234);
    chk("R10 hold", pacc_hold_o, 16'hA5A5);
    step(0, 0, 0, 1, 0, 16'h5A5A);
    chk("R10 relatch", pacc_hold_o, 16'h5A5A);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_overwrite();
    t_no_overwrite();
    t_flag_mode();
    t_pacc();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule